// File: doc/BRIEF.md
# Lock-Gated GPIO Pad Mode Controller

This block controls a bank of up to 32 general-purpose pins. For each pin, two mode bits (`mode_hi`, `mode_lo`) and a registered output bit decide the pad behaviour. The four behaviours are:

- high-impedance input;
- push-pull drive;
- open-drain (pull low only);
- open-source (pull high only).

The pad side presents a drive value and an output enable for each pin. It also samples the pad inputs through a two-flop synchronizer.

A simple register port gives software access to all state. The output bits change only through dedicated set and clear registers. The mode bits can be written directly, and they also have set or clear strobes. All mode writes are accepted only while a key-activated lock is held. A stray write therefore cannot change pin directions.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After reset every mode bit and output bit is 0, the lock is inactive, and `pad_oe_o` and `pad_o` are all zero.
- R2: A write to offset 0x00 whose bits [15:0] equal 0xD42F activates the lock. While the lock is active, a read of 0x00 returns bit 31 set and all other bits 0.
- R3: A write to 0x00 with bits [15:0] equal to 0x0000 releases the lock. Any other key value leaves the lock state unchanged. Bits [31:16] of the write are ignored.
- R4: While the lock is inactive, writes to the mode registers have no effect. This covers the direct writes at 0x08 (mode_hi) and 0x0C (mode_lo), and the strobes at 0x18 (mode_hi clear), 0x1C (mode_lo set) and 0x20 (mode_lo clear).
- R5: While the lock is active, a direct mode write replaces the whole register. A set or clear strobe changes only the pins whose write bit is 1.
- R6: Writing 0x10 sets and writing 0x14 clears the output bits of the pins whose write bit is 1; the other pins keep their value. This works regardless of the lock. A read of 0x10 returns the output bits.
- R7: With {mode_hi,mode_lo}=00 a pin is not driven (`pad_oe_o`=0, `pad_o`=0), whatever its output bit.
- R8: With 01 the pin is always driven, and `pad_o` equals the output bit.
- R9: With 10 the pin drives low (`pad_oe_o`=1, `pad_o`=0) when its output bit is 0, and floats with `pad_o`=0 when the bit is 1.
- R10: With 11 the pin floats with `pad_o`=1 when its output bit is 0, and drives high (`pad_oe_o`=1, `pad_o`=1) when the bit is 1.
- R11: A read of 0x04 returns `pad_i` delayed by a two-flop synchronizer. A change on `pad_i` becomes visible after the second rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| pad_i | input | NPINS | Pad input levels |
| pad_o | output | NPINS | Pad drive value |
| pad_oe_o | output | NPINS | Pad output enable |

## Verification
The assertions check the following on every cycle:

- the pad encoding laws: an input pin never drives, a push-pull pin mirrors its output bit, an open-drain pin never drives high, and an open-source pin never drives low;
- the mode bits stay frozen whenever the lock is inactive;
- the lock follows only the two defined keys.

Only the bench scenarios can show the remaining behaviour. These are the exact contents of registers after mixed set, clear and direct writes. They also include the two-edge synchronizer latency, which the bench observes through the data-in read, and the full lock, unlock and relock sequence as seen through readback.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 32;
  localparam logic [15:0] LOCK_KEY  = 16'hD42F;
  localparam logic [15:0] UNLOCK_KEY = 16'h0000;

  localparam logic [AW-1:0] OFS_LOCK     = 8'h00;
  localparam logic [AW-1:0] OFS_PAD_IN   = 8'h04;
  localparam logic [AW-1:0] OFS_MODE_HI  = 8'h08;
  localparam logic [AW-1:0] OFS_MODE_LO  = 8'h0C;
  localparam logic [AW-1:0] OFS_OUT_SET  = 8'h10;
  localparam logic [AW-1:0] OFS_OUT_CLR  = 8'h14;
  localparam logic [AW-1:0] OFS_HI_CLR   = 8'h18;
  localparam logic [AW-1:0] OFS_LO_SET   = 8'h1C;
  localparam logic [AW-1:0] OFS_LO_CLR   = 8'h20;
endpackage

// File: rtl/gpio_key_lock.sv
module gpio_key_lock
  import gpio_pad_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [15:0] key_i,
  output logic        active_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              active_o <= 1'b0;
    else if (wr_i && key_i == LOCK_KEY)       active_o <= 1'b1;
    else if (wr_i && key_i == UNLOCK_KEY)     active_o <= 1'b0;
  end
endmodule

// File: rtl/gpio_bit_reg.sv
module gpio_bit_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= wdata_i;
    else if (set_i)  q_o <= q_o | wdata_i;
    else if (clr_i)  q_o <= q_o & ~wdata_i;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= (s == 0) ? d_i : stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] mode_hi_i,
  input  logic [W-1:0] mode_lo_i,
  input  logic [W-1:0] out_i,
  output logic [W-1:0] pad_o,
  output logic [W-1:0] pad_oe_o
);
  for (genvar p = 0; p < W; p++) begin : g_pin
    always_comb begin
      unique case ({mode_hi_i[p], mode_lo_i[p]})
        2'b00: begin pad_o[p] = 1'b0;     pad_oe_o[p] = 1'b0;      end
        2'b01: begin pad_o[p] = out_i[p]; pad_oe_o[p] = 1'b1;      end
        2'b10: begin pad_o[p] = 1'b0;     pad_oe_o[p] = ~out_i[p]; end
        default: begin pad_o[p] = 1'b1;   pad_oe_o[p] = out_i[p];  end
      endcase
    end
  end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pad_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [NPINS-1:0] pad_i,
  output logic [NPINS-1:0] pad_o,
  output logic [NPINS-1:0] pad_oe_o
);
  logic             lock_q;
  logic [NPINS-1:0] mode_hi_q, mode_lo_q, out_q, pad_in_s;
  logic [NPINS-1:0] wbits;
  logic             mode_we;

  assign wbits   = wdata_i[NPINS-1:0];
  assign mode_we = wr_en_i && lock_q;

  gpio_key_lock i_lock (
    .clk_i, .rst_ni,
    .wr_i     (wr_en_i && addr_i == OFS_LOCK),
    .key_i    (wdata_i[15:0]),
    .active_o (lock_q)
  );

  gpio_bit_reg #(.W(NPINS)) i_mode_hi (
    .clk_i, .rst_ni,
    .load_i  (mode_we && addr_i == OFS_MODE_HI),
    .set_i   (1'b0),
    .clr_i   (mode_we && addr_i == OFS_HI_CLR),
    .wdata_i (wbits),
    .q_o     (mode_hi_q)
  );

  gpio_bit_reg #(.W(NPINS)) i_mode_lo (
    .clk_i, .rst_ni,
    .load_i  (mode_we && addr_i == OFS_MODE_LO),
    .set_i   (mode_we && addr_i == OFS_LO_SET),
    .clr_i   (mode_we && addr_i == OFS_LO_CLR),
    .wdata_i (wbits),
    .q_o     (mode_lo_q)
  );

  gpio_bit_reg #(.W(NPINS)) i_out (
    .clk_i, .rst_ni,
    .load_i  (1'b0),
    .set_i   (wr_en_i && addr_i == OFS_OUT_SET),
    .clr_i   (wr_en_i && addr_i == OFS_OUT_CLR),
    .wdata_i (wbits),
    .q_o     (out_q)
  );

  gpio_in_sync #(.W(NPINS), .STAGES(2)) i_sync (
    .clk_i, .rst_ni,
    .d_i (pad_i),
    .q_o (pad_in_s)
  );

  gpio_pad_mux #(.W(NPINS)) i_mux (
    .mode_hi_i (mode_hi_q),
    .mode_lo_i (mode_lo_q),
    .out_i     (out_q),
    .pad_o     (pad_o),
    .pad_oe_o  (pad_oe_o)
  );

  always_comb begin
    unique case (addr_i)
      OFS_LOCK:    rdata_o = {lock_q, 31'b0};
      OFS_PAD_IN:  rdata_o = DW'(pad_in_s);
      OFS_MODE_HI: rdata_o = DW'(mode_hi_q);
      OFS_MODE_LO: rdata_o = DW'(mode_lo_q);
      OFS_OUT_SET: rdata_o = DW'(out_q);
      default:     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_pad_ctrl_chk.sv
module gpio_pad_ctrl_chk
  import gpio_pad_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [AW-1:0]    addr_i,
  input logic [DW-1:0]    wdata_i,
  input logic             lock_i,
  input logic [NPINS-1:0] mode_hi_i,
  input logic [NPINS-1:0] mode_lo_i,
  input logic [NPINS-1:0] out_i,
  input logic [NPINS-1:0] pad_o,
  input logic [NPINS-1:0] pad_oe_o
);
  logic lock_wr;
  assign lock_wr = wr_en_i && addr_i == OFS_LOCK;

  p_input_undriven_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~mode_hi_i & ~mode_lo_i) & (pad_oe_o | pad_o)) == '0);

  p_push_pull_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~mode_hi_i & mode_lo_i) & ((pad_o ^ out_i) | ~pad_oe_o)) == '0);

  p_drain_never_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_hi_i & ~mode_lo_i) & pad_oe_o & pad_o) == '0);

  p_source_never_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_hi_i & mode_lo_i) & pad_oe_o & ~pad_o) == '0);

  p_mode_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_i |=> ($stable(mode_hi_i) && $stable(mode_lo_i)));

  p_key_sets_lock_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_wr && wdata_i[15:0] == LOCK_KEY) |=> lock_i);

  p_zero_drops_lock_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_wr && wdata_i[15:0] == UNLOCK_KEY) |=> !lock_i);

  p_other_key_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_wr || (wdata_i[15:0] != LOCK_KEY && wdata_i[15:0] != UNLOCK_KEY))
      |=> $stable(lock_i));
endmodule

bind gpio_pad_ctrl gpio_pad_ctrl_chk #(.NPINS(NPINS)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .lock_i    (lock_q),
  .mode_hi_i (mode_hi_q),
  .mode_lo_i (mode_lo_q),
  .out_i     (out_q),
  .pad_o     (pad_o),
  .pad_oe_o  (pad_oe_o)
);

// File: tb/test_gpio_pad_ctrl.sv
module test_gpio_pad_ctrl;
  localparam int NPINS = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [7:0]        addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NPINS-1:0]  pad_in = '0;
  logic [NPINS-1:0]  pad_out, pad_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_pad_ctrl #(.NPINS(NPINS)) i_gpio_pad_ctrl (
    .clk_i (clk), .rst_ni (rst_n), .wr_en_i (wr_en), .addr_i (addr),
    .wdata_i (wdata), .rdata_o (rdata), .pad_i (pad_in),
    .pad_o (pad_out), .pad_oe_o (pad_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); check("R1 lock", v, 32'h0);
    rd(8'h08, v); check("R1 mode_hi", v, 32'h0);
    rd(8'h0C, v); check("R1 mode_lo", v, 32'h0);
    rd(8'h10, v); check("R1 out", v, 32'h0);
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 pad_o", pad_out, 32'h0);
  endtask

  task automatic t_unlocked_ignored();
    logic [31:0] v;
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h1C, 32'h0000_000F);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h0C, v); check("R4 mode_lo unlocked", v, 32'h0);
    rd(8'h08, v); check("R4 mode_hi unlocked", v, 32'h0);
    check("R4 pad_oe unlocked", pad_oe, 32'h0);
  endtask

  task automatic t_lock_keys();
    logic [31:0] v;
    wr(8'h00, 32'h0000_1234);
    rd(8'h00, v); check("R3 bad key no lock", v, 32'h0);
    wr(8'h00, 32'hFFFF_D42F);
    rd(8'h00, v); check("R2 key locks", v, 32'h8000_0000);
    wr(8'h00, 32'h0000_5555);
    rd(8'h00, v); check("R3 bad key keeps lock", v, 32'h8000_0000);
  endtask

  task automatic t_out_and_pads();
    logic [31:0] v;
    wr(8'h10, 32'h0000_00FA);
    wr(8'h14, 32'h0000_000A);
    rd(8'h10, v); check("R6 out set/clr", v, 32'h0000_00F0);
    wr(8'h0C, 32'h0000_00AA);
    wr(8'h08, 32'h0000_00CC);
    rd(8'h0C, v); check("R5 mode_lo direct", v, 32'h0000_00AA);
    rd(8'h08, v); check("R5 mode_hi direct", v, 32'h0000_00CC);
    // pins 0,4: 00; 1,5: 01; 2,6: 10; 3,7: 11; out bits 4..7 = 1
    check("R7 R8 R9 R10 pad_oe", pad_oe, 32'h0000_00A6);
    check("R7 R8 R9 R10 pad_o", pad_out, 32'h0000_00A8);
    wr(8'h20, 32'h0000_0002);
    rd(8'h0C, v); check("R5 mode_lo clear", v, 32'h0000_00A8);
    wr(8'h1C, 32'h0000_0001);
    rd(8'h0C, v); check("R5 mode_lo set", v, 32'h0000_00A9);
    wr(8'h18, 32'h0000_0004);
    rd(8'h08, v); check("R5 mode_hi clear", v, 32'h0000_00C8);
    // pin0 now 01 out0 -> driven low; pin1 00; pin2 00
    check("R8 pin0 push-pull", pad_oe, 32'h0000_00A1);
  endtask

  task automatic t_release();
    logic [31:0] v;
    wr(8'h00, 32'hABCD_0000);
    rd(8'h00, v); check("R3 release", v, 32'h0);
    wr(8'h18, 32'h0000_00FF);
    wr(8'h0C, 32'h0);
    rd(8'h08, v); check("R4 hi clr ignored", v, 32'h0000_00C8);
    rd(8'h0C, v); check("R4 lo write ignored", v, 32'h0000_00A9);
    wr(8'h10, 32'h0000_0100);
    rd(8'h10, v); check("R6 set while unlocked", v, 32'h0000_01F0);
    wr(8'h00, 32'h0000_D42F);
    rd(8'h00, v); check("R2 relock", v, 32'h8000_0000);
  endtask

  task automatic t_sync();
    logic [31:0] v;
    @(negedge clk);
    pad_in = 32'h5A5A_0F0F;
    addr = 8'h04;
    @(negedge clk); #1;
    check("R11 after one edge", rdata, 32'h0);
    @(negedge clk); #1;
    check("R11 after two edges", rdata, 32'h5A5A_0F0F);
    rd(8'h04, v); check("R11 steady", v, 32'h5A5A_0F0F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unlocked_ignored();
    t_lock_keys();
    t_out_and_pads();
    t_release();
    t_sync();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule